// File: doc/BRIEF.md
# Byte-Bus 16-Bit Timer with Atomic Pair Access

This block is a 16-bit up-counter that software reaches through a narrow 8-bit register port with four addresses: control, counter low byte, counter high byte and status. A programmable divider sits in front of the counter. It turns each run-enabled cycle into a count step once every 1, 2, 4 or 8 cycles. When the counter steps past its top value back to zero, a sticky flag is raised. An interrupt line follows that flag whenever the interrupt enable is on.

The control register has a pair-access mode bit. With that bit set, the high-byte address reaches a holding byte and not the live high byte. A low-byte read copies the live high byte into the holding byte in the same access. A low-byte write loads the holding byte and the written low byte into the counter in a single cycle. Software can therefore read or write all sixteen bits without tearing, even while the counter runs. A separate synchronous clear input zeroes the counter and the divider. It never raises the flag, and a bus write to the counter in the same cycle wins over it.

The register port has no wait states and no back-pressure. Every selected access completes in the cycle it is presented. Read data is combinational within that cycle. There is no valid/ready stream on this block, because every pin is either a register access or a plain control or status signal.

Top module: `bytebus_timer16`

## Requirements
- R1: After reset, every register reads back zero (control, both counter bytes, status), the holding byte is zero and irq is low.
- R2: Each count step adds one to the counter. A step taken at 0xFFFF yields 0x0000 and sets the overflow flag (status bit 0) at the same clock edge.
- R3: The overflow flag stays set until a status write (address 3) has bit 0 equal to 1. If that clearing write and an overflow fall in the same cycle, the flag ends set.
- R4: irq is high exactly when the overflow flag and the interrupt enable (status bit 1, read/write) are both set.
- R5: Control bit 0 enables running, and control bits 5:4 (value s) select a step on every 2^s-th running cycle through a 3-bit divider. With bit 0 clear, neither the counter nor the divider moves. Control bit 7 is the pair-access mode, and the other control bits read zero.
- R6: A write to the low-byte address (1) clears the divider. A write to the high-byte address (2) or to the control register leaves the divider as it was.
- R7: In pair mode, a read of address 1 returns the live low byte and, at that edge, copies the live high byte into the holding byte. A read of address 2 returns the holding byte.
- R8: In pair mode, a write to address 2 changes only the holding byte, and the live high byte is unaffected. A write to address 1 loads {holding byte, written byte} into the counter.
- R9: With pair mode off, address 2 reads and writes the live high byte directly, and a write to address 1 changes only the low byte. The holding byte is neither copied nor written in this mode.
- R10: A bus write that loads the counter takes precedence over a step in the same cycle. The loaded value is not incremented in that cycle, and loading never sets the flag.
- R11: A high sync_clr zeroes the counter and the divider without setting the flag. A bus load of the counter in the same cycle takes precedence over the counter clear.
- R12: bus_rdata is zero in any cycle without a selected read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous clear of counter and divider |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 counter low, 2 counter high, 3 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| irq | output | 1 | Overflow interrupt request |

## Verification
A wrong divider phase shows up as a counter low byte that is early or late by one or more steps. The per-cycle comparison catches that on the next low-byte read, within eight cycles. A holding byte that is stale or overwritten at the wrong time is exposed by the next high-byte read in pair mode, or by the value committed on the next low-byte write. A flag that is set or cleared wrongly reaches irq in the same cycle once the enable is on. A lost step or an extra step persists in the counter, so it is visible on every read that follows.

// File: rtl/tmrb_pkg.sv
package tmrb_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CLO  = 2'd1,
    A_CHI  = 2'd2,
    A_STAT = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_PS_LSB  = 4;
  localparam int unsigned CTRL_M16_BIT = 7;
  localparam int unsigned ST_FLAG_BIT  = 0;
  localparam int unsigned ST_IE_BIT    = 1;
endpackage

// File: rtl/tmrb_prescale.sv
module tmrb_prescale #(
  parameter int unsigned PS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] ps_sel,
  input  logic            clr,
  output logic            tick
);
  localparam int unsigned PC_W = (1 << PS_W) - 1;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] mask;

  // mask has the s lowest bits set for selection s
  for (genvar g = 0; g < PC_W; g++) begin : g_mask
    assign mask[g] = (ps_sel > PS_W'(g));
  end

  assign tick = run && ((pc_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= '0;
    else if (clr)    pc_q <= '0;
    else if (run)    pc_q <= pc_q + 1'b1;
  end

  a_r6_div_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pc_q == '0));
  a_r5_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(pc_q));
endmodule

// File: rtl/tmrb_count.sv
module tmrb_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sync_clr,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt  = cnt_q;
  assign wrap = tick && !ld_en && !sync_clr && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (ld_en)     cnt_q <= ld_val;
    else if (sync_clr)  cnt_q <= '0;
    else if (tick)      cnt_q <= cnt_q + 1'b1;
  end

  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (cnt_q == $past(ld_val)));
  a_r11_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_clr && !ld_en) |=> (cnt_q == '0));
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_en && !sync_clr) |=> $stable(cnt_q));
endmodule

// File: rtl/tmrb_regbus.sv
module tmrb_regbus
  import tmrb_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PS_W   = 2,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrap,
  output logic              run,
  output logic [PS_W-1:0]   ps_sel,
  output logic              lo_wr,
  output logic              ld_en,
  output logic [CNT_W-1:0]  ld_val,
  output logic              irq
);
  logic              run_q, m16_q, flag_q, ie_q;
  logic [PS_W-1:0]   ps_q;
  logic [BYTE_W-1:0] hbuf_q;
  reg_addr_e         addr;
  logic              rd_acc, wr_acc;
  logic              hi_wr, ctrl_wr, st_wr, lo_rd, flag_clr;
  logic [BYTE_W-1:0] live_hi, live_lo;

  assign addr    = reg_addr_e'(bus_addr);
  assign rd_acc  = bus_sel && !bus_wr;
  assign wr_acc  = bus_sel && bus_wr;
  assign lo_wr   = wr_acc && (addr == A_CLO);
  assign hi_wr   = wr_acc && (addr == A_CHI);
  assign ctrl_wr = wr_acc && (addr == A_CTRL);
  assign st_wr   = wr_acc && (addr == A_STAT);
  assign lo_rd   = rd_acc && (addr == A_CLO);
  assign flag_clr = st_wr && bus_wdata[ST_FLAG_BIT];
  assign live_hi = cnt[CNT_W-1 -: BYTE_W];
  assign live_lo = cnt[BYTE_W-1:0];

  assign run    = run_q;
  assign ps_sel = ps_q;
  assign irq    = flag_q && ie_q;

  // counter load: pair mode commits the holding byte, byte mode touches one byte
  assign ld_en = lo_wr || (hi_wr && !m16_q);
  always_comb begin
    if (lo_wr) ld_val = {(m16_q ? hbuf_q : live_hi), bus_wdata};
    else       ld_val = {bus_wdata, live_lo};
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      unique case (addr)
        A_CTRL: begin
          bus_rdata[CTRL_M16_BIT]             = m16_q;
          bus_rdata[CTRL_PS_LSB +: PS_W]      = ps_q;
          bus_rdata[CTRL_RUN_BIT]             = run_q;
        end
        A_CLO:  bus_rdata = live_lo;
        A_CHI:  bus_rdata = m16_q ? hbuf_q : live_hi;
        A_STAT: begin
          bus_rdata[ST_FLAG_BIT] = flag_q;
          bus_rdata[ST_IE_BIT]   = ie_q;
        end
        default: bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      m16_q <= 1'b0;
      ps_q  <= '0;
    end else if (ctrl_wr) begin
      run_q <= bus_wdata[CTRL_RUN_BIT];
      m16_q <= bus_wdata[CTRL_M16_BIT];
      ps_q  <= bus_wdata[CTRL_PS_LSB +: PS_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hbuf_q <= '0;
    else if (m16_q && lo_rd)   hbuf_q <= live_hi;
    else if (m16_q && hi_wr)   hbuf_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      flag_q <= (flag_q && !flag_clr) || wrap;
      if (st_wr) ie_q <= bus_wdata[ST_IE_BIT];
    end
  end

  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);
  a_r2_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag_q);
  a_r7_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    (m16_q && lo_rd) |=> (hbuf_q == $past(live_hi)));
  a_r9_buffer_still: assert property (@(posedge clk) disable iff (!rst_n)
    !m16_q |=> $stable(hbuf_q));
  a_r12_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |-> (bus_rdata == '0));
endmodule

// File: rtl/bytebus_timer16.sv
module bytebus_timer16 #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PS_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_clr,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic              run, lo_wr, ld_en, tick, wrap;
  logic [PS_W-1:0]   ps_sel;
  logic [CNT_W-1:0]  ld_val, cnt;

  tmrb_regbus #(.BYTE_W(BYTE_W), .PS_W(PS_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .wrap(wrap),
    .run(run), .ps_sel(ps_sel), .lo_wr(lo_wr),
    .ld_en(ld_en), .ld_val(ld_val), .irq(irq)
  );

  tmrb_prescale #(.PS_W(PS_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .ps_sel(ps_sel),
    .clr(lo_wr || sync_clr), .tick(tick)
  );

  tmrb_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sync_clr(sync_clr),
    .ld_en(ld_en), .ld_val(ld_val), .cnt(cnt), .wrap(wrap)
  );

  a_r4_irq_from_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(wrap) || $past(bus_sel && bus_wr && bus_addr == 2'd3)));
endmodule

// File: tb/bytebus_timer16_bench.sv
module bytebus_timer16_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_clr = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq;

  always #10 clk = ~clk;

  bytebus_timer16 u_bytebus_timer16 (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int m_cnt = 0, m_psc = 0, m_hbuf = 0, m_ctrl = 0, m_flag = 0, m_ie = 0;

  task automatic check(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_rdata();
    if (!(bus_sel && !bus_wr)) return 0;
    case (bus_addr)
      2'd0: return m_ctrl;
      2'd1: return m_cnt & 255;
      2'd2: return m_ctrl[7] ? m_hbuf : (m_cnt >> 8);
      default: return (m_ie << 1) | m_flag;
    endcase
  endfunction

  task automatic model_edge();
    int div, n_cnt, n_psc, n_hbuf, n_flag, wd;
    bit m16, run, tick, wrapped, rdl, wlo, whi, wct, wst;
    m16 = m_ctrl[7]; run = m_ctrl[0];
    div = 1 << ((m_ctrl >> 4) & 3);
    wd  = int'(bus_wdata);
    rdl = bus_sel && !bus_wr && bus_addr == 2'd1;
    wlo = bus_sel && bus_wr && bus_addr == 2'd1;
    whi = bus_sel && bus_wr && bus_addr == 2'd2;
    wct = bus_sel && bus_wr && bus_addr == 2'd0;
    wst = bus_sel && bus_wr && bus_addr == 2'd3;
    tick = run && ((m_psc % div) == div - 1);
    n_psc = (wlo || sync_clr) ? 0 : (run ? (m_psc + 1) % 8 : m_psc);
    wrapped = 0;
    n_cnt = m_cnt;
    if (wlo) n_cnt = ((m16 ? m_hbuf : (m_cnt >> 8)) << 8) | wd;
    else if (whi && !m16) n_cnt = (wd << 8) | (m_cnt & 255);
    else if (sync_clr) n_cnt = 0;
    else if (tick) begin
      if (m_cnt == 65535) begin n_cnt = 0; wrapped = 1; end
      else n_cnt = m_cnt + 1;
    end
    n_hbuf = m_hbuf;
    if (m16 && rdl) n_hbuf = m_cnt >> 8;
    else if (m16 && whi) n_hbuf = wd;
    n_flag = m_flag;
    if (wst && wd[0]) n_flag = 0;
    if (wrapped) n_flag = 1;
    if (wst) m_ie = (wd >> 1) & 1;
    if (wct) m_ctrl = wd & 'hB1;
    m_cnt = n_cnt; m_psc = n_psc; m_hbuf = n_hbuf; m_flag = n_flag;
  endtask

  task automatic step(string tag, bit s, bit w, int a, int d, bit sc);
    bus_sel = s; bus_wr = w; bus_addr = 2'(a); bus_wdata = 8'(d); sync_clr = sc;
    #1;
    check(tag, "rdata", int'(bus_rdata), exp_rdata());
    check(tag, "irq", int'(irq), m_flag & m_ie);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0);
  endtask
  task automatic wreg(string tag, int a, int d); step(tag, 1, 1, a, d, 0); endtask
  task automatic rreg(string tag, int a);        step(tag, 1, 0, a, 0, 0); endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    for (int a = 0; a < 4; a++) rreg("R1", a);
    // R12: no read access gives zero
    idle("R12", 2);
    wreg("R12", 3, 0);
    // R2 / R5: divide by one, count and read
    wreg("R5", 0, 'h01);
    idle("R2", 3);
    rreg("R2", 1);
    // R9 / R10: byte-mode loads while running
    wreg("R9", 2, 'hFF);
    wreg("R10", 1, 'hFA);
    rreg("R9", 2);
    for (int i = 0; i < 8; i++) rreg("R2", 1);
    rreg("R3", 3);
    // R4: enable turns irq on
    wreg("R4", 3, 'h02);
    idle("R4", 2);
    wreg("R3", 3, 'h03);
    rreg("R3", 3);
    // R3: overflow coinciding with clear keeps the flag
    wreg("R10", 1, 'hFF);
    wreg("R3", 3, 'h03);
    rreg("R3", 3);
    wreg("R3", 3, 'h01);
    rreg("R4", 3);
    // R5: other divide settings and stop
    for (int s = 1; s < 4; s++) begin
      wreg("R5", 0, (s << 4) | 1);
      for (int i = 0; i < 10; i++) rreg("R5", 1);
    end
    wreg("R5", 0, 'h30);
    idle("R5", 5);
    rreg("R5", 1);
    rreg("R5", 0);
    // R6: divider clear rules
    wreg("R6", 0, 'h31);
    idle("R6", 3);
    wreg("R6", 2, 'h40);
    for (int i = 0; i < 9; i++) rreg("R6", 1);
    wreg("R6", 0, 'h21);
    wreg("R6", 1, 'h10);
    for (int i = 0; i < 9; i++) rreg("R6", 1);
    // R7 / R8: pair mode
    wreg("R8", 0, 'h81);
    wreg("R8", 2, 'h12);
    rreg("R8", 2);
    wreg("R8", 1, 'hF8);
    for (int i = 0; i < 6; i++) begin
      rreg("R7", 1);
      rreg("R7", 2);
    end
    wreg("R8", 2, 'h55);
    rreg("R8", 1);
    rreg("R8", 2);
    wreg("R8", 1, 'h00);
    rreg("R7", 1);
    rreg("R7", 2);
    // R9: leaving pair mode reads live high, buffer untouched by lo read
    wreg("R9", 0, 'h01);
    rreg("R9", 2);
    rreg("R9", 1);
    // R11: synchronous clear
    step("R11", 0, 0, 0, 0, 1);
    rreg("R11", 1);
    step("R11", 1, 1, 1, 'h77, 1);
    rreg("R11", 1);
    wreg("R11", 3, 'h03);
    wreg("R11", 2, 'hFF);
    wreg("R11", 1, 'hFF);
    step("R11", 0, 0, 0, 0, 1);
    rreg("R11", 3);
    rreg("R11", 2);
    // R1: reset again mid-run
    rst_n = 1'b0;
    m_cnt = 0; m_psc = 0; m_hbuf = 0; m_ctrl = 0; m_flag = 0; m_ie = 0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) rreg("R1", a);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule